// File: doc/BRIEF.md
# Diagnostic Block-Read Responder

This block answers diagnostic requests that ask for one numbered data block. A request comes in as a six-byte stream: three header bytes, a mode byte, a block number and a check byte. The block accepts the request only if the mode is `$3C` and the target header byte names this node (`$10`) or all nodes (`$FE`). It then looks the block number up in a fixed sparse table that gives a start address and a byte count. It reads those bytes from a local synchronous memory port and streams out a response frame.

The response reuses the first header byte and swaps the target and source bytes. Next come the request mode plus `$40` and the block number, then the data, and last a check byte taken from a side input. Block `$01` is special: its first data byte is always zero, and the five bytes that follow are read from the table address onward. Requests with a wrong target, a wrong mode or an unknown block get no response; each one increments a drop counter. Both byte streams use valid/ready handshakes. A new request is taken only once the previous response has fully left.

Top module: `diag_block_reader`

## Requirements
- R1: After reset, `tx_valid` is 0, `rx_ready` is 1, `mem_en` is 0 and `drop_count` is 0.
- R2: A request is answered only if its byte 3 (mode) is `$3C` and its byte 1 (target) is `$10` or `$FE`. Otherwise no byte is sent and `drop_count` rises by exactly 1.
- R3: A request whose byte 4 (block number) is not one of `$01`-`$08`, `$0A`, `$0B`, `$40`-`$49` or `$A0` gets no response and raises `drop_count` by 1.
- R4: The first three response bytes are request byte 0, request byte 2 (source) and request byte 1 (target), in that order.
- R5: Response byte 3 is the request mode plus `$40` (`$7C`), and response byte 4 is the block number.
- R6: After these come the block's data bytes, in a count that depends on the block (1 to 6). They are read from consecutive addresses starting at the block's table address. Examples: `$0A` gives 4 bytes from `$2000`, `$40` gives 2 bytes from `$182A`, `$A0` gives 1 byte from `$0E35`, and `$49` gives 5 bytes from `$185A`.
- R7: For block `$01`, the first data byte is `$00`. It is followed by five bytes read from `$0E24` through `$0E28`.
- R8: The final response byte is the value on `chk_in`, and `tx_last` is high with that byte only.
- R9: `rx_ready` is low from the clock edge that accepts the last byte of a valid request until the final response byte is accepted. At all other times it is high. The request's check byte has no effect on the response.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R11: `mem_en` is high only while a response is in progress. Read data is taken one cycle after `mem_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Request byte valid |
| rx_data | input | 8 | Request byte |
| rx_ready | output | 1 | Request byte accepted when high together with rx_valid |
| tx_valid | output | 1 | Response byte valid |
| tx_data | output | 8 | Response byte |
| tx_last | output | 1 | Marks the final response byte |
| tx_ready | input | 1 | Downstream takes the response byte |
| chk_in | input | 8 | Check byte to append to the response |
| mem_en | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after mem_en |
| drop_count | output | 8 | Count of rejected requests, wrapping |

## Verification
The assertions assume the downstream side follows the handshake, so the hold check is meaningful only when tx_ready is a plain level input. They also assume the memory returns data exactly one cycle after its strobe. The bench's memory model answers with a fixed function of the address, one cycle after the strobe. It keeps `chk_in` constant from the start of each request until its response ends, because the check byte is sampled late in the frame. tx_ready is driven either always high or at random, to exercise the stall hold.

// File: rtl/dbr_pkg.sv
`timescale 1ns/1ps
package dbr_pkg;
  localparam int ADDR_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int LEN_W   = 3;
  localparam int REQ_LEN = 6;
  localparam int HDR_N   = 5;
  localparam logic [BYTE_W-1:0] RESP_OFS = 8'h40;
  localparam logic [BYTE_W-1:0] LEAD_BLK = 8'h01;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] base;
    logic [LEN_W-1:0]  len;
  } blk_ent_t;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_HDR, SQ_DREQ, SQ_DCAP, SQ_DPUT, SQ_CHK, SQ_DRAIN
  } seq_st_t;

  function automatic blk_ent_t blk_lookup(input logic [BYTE_W-1:0] n);
    blk_ent_t e;
    case (n)
      8'h01: e = '{1'b1, 16'h0E24, 3'd6};
      8'h02: e = '{1'b1, 16'h0E29, 3'd6};
      8'h03: e = '{1'b1, 16'h0E2F, 3'd6};
      8'h04: e = '{1'b1, 16'h0E04, 3'd4};
      8'h05: e = '{1'b1, 16'h0E08, 3'd4};
      8'h06: e = '{1'b1, 16'h0E0C, 3'd4};
      8'h07: e = '{1'b1, 16'h0E10, 3'd4};
      8'h08: e = '{1'b1, 16'h0E20, 3'd4};
      8'h0A: e = '{1'b1, 16'h2000, 3'd4};
      8'h0B: e = '{1'b1, 16'h0262, 3'd4};
      8'h40: e = '{1'b1, 16'h182A, 3'd2};
      8'h41: e = '{1'b1, 16'h182C, 3'd6};
      8'h42: e = '{1'b1, 16'h1832, 3'd6};
      8'h43: e = '{1'b1, 16'h1838, 3'd5};
      8'h44: e = '{1'b1, 16'h183D, 3'd6};
      8'h45: e = '{1'b1, 16'h1843, 3'd6};
      8'h46: e = '{1'b1, 16'h1849, 3'd5};
      8'h47: e = '{1'b1, 16'h184E, 3'd6};
      8'h48: e = '{1'b1, 16'h1854, 3'd6};
      8'h49: e = '{1'b1, 16'h185A, 3'd5};
      8'hA0: e = '{1'b1, 16'h0E35, 3'd1};
      default: e = '{1'b0, 16'h0000, 3'd0};
    endcase
    return e;
  endfunction
endpackage

// File: rtl/dbr_rx_frame.sv
`timescale 1ns/1ps
module dbr_rx_frame
  import dbr_pkg::*;
#(
  parameter int FRAME_LEN = REQ_LEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              busy,
  output logic              rx_ready,
  output logic              frm_done,
  output logic [BYTE_W-1:0] f_bytes [FRAME_LEN-1]
);
  localparam int CNT_W = $clog2(FRAME_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign rx_ready = !busy;
  assign take     = rx_valid && rx_ready;
  assign frm_done = take && (cnt_q == CNT_W'(FRAME_LEN-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= frm_done ? '0 : cnt_q + 1'b1;
    end
  end

  // one capture register per stored position; the trailing check byte is not kept
  for (genvar i = 0; i < FRAME_LEN-1; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        f_bytes[i] <= '0;
      end else if (take && cnt_q == CNT_W'(i)) begin
        f_bytes[i] <= rx_data;
      end
    end
  end
endmodule

// File: rtl/dbr_blk_table.sv
`timescale 1ns/1ps
module dbr_blk_table
  import dbr_pkg::*;
(
  input  logic [BYTE_W-1:0] blk,
  output logic              hit,
  output logic [ADDR_W-1:0] base,
  output logic [LEN_W-1:0]  len,
  output logic              lead_zero
);
  blk_ent_t ent;

  always_comb begin
    ent       = blk_lookup(blk);
    hit       = ent.hit;
    base      = ent.base;
    len       = ent.len;
    lead_zero = (blk == LEAD_BLK);
  end
endmodule

// File: rtl/dbr_tx_seq.sv
`timescale 1ns/1ps
module dbr_tx_seq
  import dbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [BYTE_W-1:0] h0,
  input  logic [BYTE_W-1:0] tgt,
  input  logic [BYTE_W-1:0] src,
  input  logic [BYTE_W-1:0] mode,
  input  logic [BYTE_W-1:0] blk,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              lead_zero,
  input  logic [BYTE_W-1:0] chk_in,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy
);
  localparam int IDX_W = $clog2(HDR_N);

  seq_st_t           st_q;
  logic [BYTE_W-1:0] hdr_q [HDR_N];
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  dcnt_q;
  logic [LEN_W-1:0]  len_q;
  logic [ADDR_W-1:0] base_q;
  logic              lead_q;
  logic [BYTE_W-1:0] hold_q;
  logic              slot_free;
  logic              lead_now;

  assign slot_free = !tx_valid || tx_ready;
  assign lead_now  = lead_q && (dcnt_q == '0);
  assign busy      = (st_q != SQ_IDLE);
  assign mem_en    = (st_q == SQ_DREQ) && !lead_now;
  assign mem_addr  = base_q + ADDR_W'(dcnt_q) - ADDR_W'(lead_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= SQ_IDLE;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_last  <= 1'b0;
      idx_q    <= '0;
      dcnt_q   <= '0;
      len_q    <= '0;
      base_q   <= '0;
      lead_q   <= 1'b0;
      hold_q   <= '0;
      for (int i = 0; i < HDR_N; i++) hdr_q[i] <= '0;
    end else begin
      if (tx_valid && tx_ready) tx_valid <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (start) begin
            hdr_q[0] <= h0;
            hdr_q[1] <= src;
            hdr_q[2] <= tgt;
            hdr_q[3] <= mode + RESP_OFS;
            hdr_q[4] <= blk;
            base_q   <= base;
            len_q    <= len;
            lead_q   <= lead_zero;
            idx_q    <= '0;
            dcnt_q   <= '0;
            st_q     <= SQ_HDR;
          end
        end
        SQ_HDR: begin
          if (slot_free) begin
            tx_data  <= hdr_q[idx_q];
            tx_valid <= 1'b1;
            tx_last  <= 1'b0;
            if (idx_q == IDX_W'(HDR_N-1)) st_q <= SQ_DREQ;
            else idx_q <= idx_q + 1'b1;
          end
        end
        SQ_DREQ: begin
          if (lead_now) begin
            hold_q <= '0;
            st_q   <= SQ_DPUT;
          end else begin
            st_q <= SQ_DCAP;
          end
        end
        SQ_DCAP: begin
          hold_q <= mem_rdata;
          st_q   <= SQ_DPUT;
        end
        SQ_DPUT: begin
          if (slot_free) begin
            tx_data  <= hold_q;
            tx_valid <= 1'b1;
            if (dcnt_q == len_q - 1'b1) begin
              st_q <= SQ_CHK;
            end else begin
              dcnt_q <= dcnt_q + 1'b1;
              st_q   <= SQ_DREQ;
            end
          end
        end
        SQ_CHK: begin
          if (slot_free) begin
            tx_data  <= chk_in;
            tx_valid <= 1'b1;
            tx_last  <= 1'b1;
            st_q     <= SQ_DRAIN;
          end
        end
        SQ_DRAIN: begin
          if (tx_valid && tx_ready) begin
            tx_last <= 1'b0;
            st_q    <= SQ_IDLE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/diag_block_reader.sv
`timescale 1ns/1ps
module diag_block_reader
  import dbr_pkg::*;
#(
  parameter int                DROP_W   = 8,
  parameter logic [BYTE_W-1:0] MODE_ID  = 8'h3C,
  parameter logic [BYTE_W-1:0] NODE_ID  = 8'h10,
  parameter logic [BYTE_W-1:0] BCAST_ID = 8'hFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] chk_in,
  output logic              mem_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [DROP_W-1:0] drop_count
);
  logic              frm_done;
  logic [BYTE_W-1:0] f_bytes [REQ_LEN-1];
  logic              busy;
  logic              hit, lead_zero;
  logic [ADDR_W-1:0] base;
  logic [LEN_W-1:0]  len;
  logic              req_ok;
  logic              start;

  dbr_rx_frame #(.FRAME_LEN(REQ_LEN)) u_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(busy), .rx_ready(rx_ready), .frm_done(frm_done), .f_bytes(f_bytes)
  );

  dbr_blk_table u_tbl (
    .blk(f_bytes[4]), .hit(hit), .base(base), .len(len), .lead_zero(lead_zero)
  );

  assign req_ok = hit && (f_bytes[3] == MODE_ID) &&
                  ((f_bytes[1] == NODE_ID) || (f_bytes[1] == BCAST_ID));
  assign start  = frm_done && req_ok;

  always_ff @(posedge clk) begin
    if (rst) drop_count <= '0;
    else if (frm_done && !req_ok) drop_count <= drop_count + 1'b1;
  end

  dbr_tx_seq u_seq (
    .clk(clk), .rst(rst), .start(start),
    .h0(f_bytes[0]), .tgt(f_bytes[1]), .src(f_bytes[2]),
    .mode(f_bytes[3]), .blk(f_bytes[4]),
    .base(base), .len(len), .lead_zero(lead_zero),
    .chk_in(chk_in), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .busy(busy)
  );
endmodule

// File: rtl/dbr_checker.sv
`timescale 1ns/1ps
module dbr_checker #(
  parameter int DROP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              tx_ready,
  input logic              mem_en,
  input logic [DROP_W-1:0] drop_count
);
  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R9
  rx_block_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !rx_ready);

  // R11
  mem_idle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> !rx_ready);

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);

  // R2
  drop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + DROP_W'(1)));
endmodule

bind diag_block_reader dbr_checker #(.DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .rx_ready(rx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
  .mem_en(mem_en), .drop_count(drop_count)
);

// File: tb/sim_diag_block_reader.sv
`timescale 1ns/1ps
module sim_diag_block_reader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_ready;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_last;
  logic       tx_ready = 1'b1;
  logic [7:0] chk_in = 8'h00;
  logic       mem_en;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic [7:0] drop_count;

  int errors = 0;
  int checks = 0;
  bit thr = 0;
  bit finished = 0;

  logic [8:0] expq [$];
  string      tagq [$];
  logic [7:0] frm [$];
  int         exp_drops = 0;
  bit         prev_stall = 0;
  logic [7:0] prev_data;
  logic       prev_last;

  diag_block_reader u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .chk_in(chk_in),
    .mem_en(mem_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .drop_count(drop_count)
  );

  always #(HALF) clk = ~clk;

  function automatic logic [7:0] memfn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h96;
  endfunction

  always_ff @(posedge clk) if (mem_en) mem_rdata <= memfn(mem_addr);

  always @(negedge clk) tx_ready <= thr ? 1'($urandom % 2) : 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent table of supported blocks
  task automatic ref_tbl(input logic [7:0] n, output bit ok, output int base, output int len);
    ok = 1;
    case (n)
      8'h01: begin base = 'h0E24; len = 6; end
      8'h02: begin base = 'h0E29; len = 6; end
      8'h03: begin base = 'h0E2F; len = 6; end
      8'h04: begin base = 'h0E04; len = 4; end
      8'h05: begin base = 'h0E08; len = 4; end
      8'h06: begin base = 'h0E0C; len = 4; end
      8'h07: begin base = 'h0E10; len = 4; end
      8'h08: begin base = 'h0E20; len = 4; end
      8'h0A: begin base = 'h2000; len = 4; end
      8'h0B: begin base = 'h0262; len = 4; end
      8'hA0: begin base = 'h0E35; len = 1; end
      8'h40: begin base = 'h182A; len = 2; end
      8'h41: begin base = 'h182C; len = 6; end
      8'h42: begin base = 'h1832; len = 6; end
      8'h43: begin base = 'h1838; len = 5; end
      8'h44: begin base = 'h183D; len = 6; end
      8'h45: begin base = 'h1843; len = 6; end
      8'h46: begin base = 'h1849; len = 5; end
      8'h47: begin base = 'h184E; len = 6; end
      8'h48: begin base = 'h1854; len = 6; end
      8'h49: begin base = 'h185A; len = 5; end
      default: begin ok = 0; base = 0; len = 0; end
    endcase
  endtask

  task automatic model_frame();
    bit ok; int base, len;
    ref_tbl(frm[4], ok, base, len);
    if (ok && frm[3] == 8'h3C && (frm[1] == 8'h10 || frm[1] == 8'hFE)) begin
      expq.push_back({1'b0, frm[0]}); tagq.push_back("R4");
      expq.push_back({1'b0, frm[2]}); tagq.push_back("R4");
      expq.push_back({1'b0, frm[1]}); tagq.push_back("R4");
      expq.push_back({1'b0, 8'(frm[3] + 8'h40)}); tagq.push_back("R5");
      expq.push_back({1'b0, frm[4]}); tagq.push_back("R5");
      if (frm[4] == 8'h01) begin
        expq.push_back(9'h000); tagq.push_back("R7");
        for (int k = 0; k < 5; k++) begin
          expq.push_back({1'b0, memfn(16'(base + k))}); tagq.push_back("R7");
        end
      end else begin
        for (int k = 0; k < len; k++) begin
          expq.push_back({1'b0, memfn(16'(base + k))}); tagq.push_back("R6");
        end
      end
      expq.push_back({1'b1, chk_in}); tagq.push_back("R8");
    end else begin
      exp_drops++;
    end
    frm.delete();
  endtask

  // monitor: samples one time unit before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #(HALF-1);
      if (!rst) begin
        if (mem_en) check(!rx_ready, "R11 mem_en while idle", rx_ready, 0);
        check(rx_ready == (expq.size() == 0), "R9 rx_ready", rx_ready, expq.size() == 0);
        if (prev_stall)
          check(tx_valid && tx_data == prev_data && tx_last == prev_last,
                "R10 hold under stall", {tx_valid, tx_last, tx_data}, {2'b11 & {1'b1, prev_last}, prev_data});
        check(drop_count == 8'(exp_drops), "R2 R3 drop_count", drop_count, exp_drops);
        if (tx_valid && tx_ready) begin
          if (expq.size() == 0) begin
            check(0, "R2 R3 unexpected response byte", tx_data, 0);
          end else begin
            logic [8:0] e; string t;
            e = expq.pop_front(); t = tagq.pop_front();
            check({tx_last, tx_data} == e, t, {tx_last, tx_data}, e);
          end
        end
        prev_stall = tx_valid && !tx_ready;
        prev_data  = tx_data;
        prev_last  = tx_last;
        if (rx_valid && rx_ready) begin
          frm.push_back(rx_data);
          if (frm.size() == 6) model_frame();
        end
      end
    end
  end

  task automatic send_frame(input logic [7:0] h0, h1, h2, md, bk, ck, input int gap);
    logic [7:0] fb [6];
    bit ok;
    fb = '{h0, h1, h2, md, bk, ck};
    ok = 0;
    while (!ok) begin
      #(HALF-1); ok = rx_ready; @(negedge clk);
    end
    chk_in = 8'($urandom);
    for (int i = 0; i < 6; i++) begin
      rx_valid = 1'b1; rx_data = fb[i];
      ok = 0;
      while (!ok) begin
        #(HALF-1); ok = rx_ready; @(negedge clk);
      end
      rx_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic drain();
    while (expq.size() != 0 || !rx_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #(HALF-1);
    // R1 reset state
    check(!tx_valid, "R1 tx_valid", tx_valid, 0);
    check(rx_ready, "R1 rx_ready", rx_ready, 1);
    check(!mem_en, "R1 mem_en", mem_en, 0);
    check(drop_count == 0, "R1 drop_count", drop_count, 0);
    @(negedge clk);

    // R4 R5 R6: plain request
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'h0A, 8'h11, 0);
    // R7: leading zero block
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'h01, 8'h22, 1);
    // R2: broadcast target accepted
    send_frame(8'h6C, 8'hFE, 8'hF1, 8'h3C, 8'h40, 8'h33, 0);
    // R6: one-byte block
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'hA0, 8'h44, 0);
    drain();
    // R2: wrong mode, wrong target
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3B, 8'h0A, 8'h00, 0);
    send_frame(8'h4C, 8'h11, 8'hF0, 8'h3C, 8'h0A, 8'h00, 0);
    drain();
    check(drop_count == 2 && !tx_valid, "R2 rejected requests", drop_count, 2);
    // R3: unsupported blocks
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'h09, 8'h00, 0);
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'h4A, 8'h00, 2);
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'h00, 8'h00, 0);
    drain();
    check(drop_count == 5 && !tx_valid, "R3 unknown blocks", drop_count, 5);
    // R9: request check byte has no effect (same block, different check bytes)
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'h49, 8'h00, 0);
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'h49, 8'hFF, 0);
    // R10: throttled output over every block number
    thr = 1;
    for (int b = 0; b < 256; b++) begin
      send_frame(8'h4C, (b % 3 == 0) ? 8'hFE : 8'h10, 8'hF2, 8'h3C, 8'(b), 8'(b), b % 2);
    end
    drain();
    thr = 0;
    send_frame(8'h4C, 8'h10, 8'hF0, 8'h3C, 8'h01, 8'h5A, 0);
    drain();
    check(expq.size() == 0, "R8 all responses complete", expq.size(), 0);
    check(drop_count == 8'(exp_drops), "R3 final drop_count", drop_count, exp_drops);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule